// File: doc/BRIEF.md
# Time-Sliced Multi-Plane Cell Crossbar

This block is the switching core of an N-port cell switch whose capacity comes from K identical crossbar planes, each running at one K-th of the line rate. The fabric never stripes a cell across planes. Every cell goes whole into one plane, which moves it to its output a slice at a time over K cell times. One clock cycle is one cell time. Each cycle, every input may present one cell with a valid flag, and the scheduler presents one matching as an output-indexed source vector with a valid bit per output.

A slot counter hands successive matchings to the planes in rotation. When its turn comes, a plane captures the matching and the cells of all inputs. It holds that crosspoint setting unchanged for the next K cycles while slices cross it. Each plane finishes a cell set in the same cycle it captures the next one, so outputs are served from the planes in assignment order. A cell therefore leaves exactly K+1 cycles after it entered, and cells from any one input keep their order. A matching that names the same input for two valid outputs is refused: the error flag rises and the whole decision is dropped.

Top module: `tsx_fabric`

## Requirements
- R1: While reset is held and in the first cycle after it, out_vld, out_cell and perm_err are all zero.
- R2: A cell presented with in_vld on input s (bits [s*CELL_W +: CELL_W]), in a cycle where output o has perm_vld[o]=1 and perm_src field [o*SRC_W +: SRC_W] equal to s, appears on out_cell field o with out_vld[o]=1, bit-exact, exactly K+1 cycles later.
- R3: A new matching is accepted every cycle, and each cell is switched according to the matching presented in its own cycle, even when the matching changes every cycle.
- R4: A sequence of cells from one input to one output in consecutive cycles leaves in the same order on consecutive cycles, with no gaps.
- R5: An output whose perm_vld bit is 0 emits idle for that slot K+1 cycles later: out_vld bit 0 and its out_cell field all zero.
- R6: An output whose valid entry names an input with in_vld 0 emits idle (valid 0, data zero) for that slot.
- R7: If two outputs with perm_vld set name the same source, perm_err is 1 in the next cycle, and every output is idle for that slot K+1 cycles later.
- R8: Equal source fields are not an error when at least one of the two entries has perm_vld 0: perm_err stays 0 and the valid entry is switched normally.
- R9: A refused matching affects only its own slot: the slots just before and after it are switched normally, and perm_err falls back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell-time clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised on release inside |
| in_cell | input | N_PORTS*CELL_W | One cell per input, input i in field i |
| in_vld | input | N_PORTS | Cell present flag per input |
| perm_src | input | N_PORTS*SRC_W | Source input index per output, output o in field o |
| perm_vld | input | N_PORTS | Entry valid flag per output |
| out_cell | output | N_PORTS*CELL_W | Switched cell per output, zero when idle |
| out_vld | output | N_PORTS | Cell present flag per output |
| perm_err | output | 1 | Previous cycle's matching had a duplicate source |

## Verification
The bench builds the fabric with four ports, four planes and 32-bit cells, so each plane carries 8-bit slices and four matchings are in flight at once. With the plane count equal to the port count, a matching that rotates every cycle puts a different setting in every plane at once. Any mix-up of planes, slices or slot order then corrupts data visibly. The K+1 latency is short enough that single-cycle faults such as a dropped matching or a leaked error slot show up next to correctly switched neighbours.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  // width of an index able to address n items (at least one bit)
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tsx_slot_ctr.sv
module tsx_slot_ctr
  import tsx_pkg::*;
#(
  parameter int N_PLANES = 4,
  localparam int SLOT_W = idx_w(N_PLANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              at_last;

  always_comb begin
    at_last = (slot_q == SLOT_W'(N_PLANES - 1));
    slot_d  = at_last ? '0 : slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;

  // R3: rotation returns to plane 0 after the last plane
  p_slot_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SLOT_W'(N_PLANES - 1)) |=> (slot_q == '0));
endmodule

// File: rtl/tsx_dup_check.sv
module tsx_dup_check #(
  parameter int N_PORTS = 4,
  parameter int SRC_W   = 2
) (
  input  logic [N_PORTS*SRC_W-1:0] perm_src,
  input  logic [N_PORTS-1:0]       perm_vld,
  output logic                     dup
);
  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < N_PORTS; a++) begin
      for (int b = a + 1; b < N_PORTS; b++) begin
        if (perm_vld[a] && perm_vld[b] &&
            (perm_src[a*SRC_W +: SRC_W] == perm_src[b*SRC_W +: SRC_W]))
          dup = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsx_plane.sv
module tsx_plane
  import tsx_pkg::*;
#(
  parameter int N_PORTS  = 4,
  parameter int N_PLANES = 4,
  parameter int CELL_W   = 32,
  localparam int SRC_W   = idx_w(N_PORTS),
  localparam int SLICE_W = CELL_W / N_PLANES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [N_PORTS*CELL_W-1:0] in_cell,
  input  logic [N_PORTS-1:0]        in_vld,
  input  logic [N_PORTS*SRC_W-1:0]  cfg_src,
  input  logic [N_PORTS-1:0]        cfg_vld,
  output logic [N_PORTS*CELL_W-1:0] done_cell,
  output logic [N_PORTS-1:0]        done_vld
);
  // held crosspoint setting
  logic [N_PORTS-1:0][SRC_W-1:0]  src_q, src_d;
  logic [N_PORTS-1:0]             cv_q, cv_d;
  logic [N_PORTS-1:0]             iv_q, iv_d;
  // per-input serialiser and per-output reassembly
  logic [N_PORTS-1:0][CELL_W-1:0] sh_q, sh_d;
  logic [N_PORTS-1:0][CELL_W-1:0] acc_q, acc_d;
  logic [N_PORTS-1:0][SLICE_W-1:0] xslice;
  logic [N_PORTS-1:0]             route_ok;

  // crossbar: each output taps the low slice of its selected input
  always_comb begin
    for (int o = 0; o < N_PORTS; o++) begin
      route_ok[o] = cv_q[o] && (int'(src_q[o]) < N_PORTS);
      xslice[o]   = route_ok[o] ? sh_q[src_q[o]][SLICE_W-1:0] : '0;
      done_vld[o] = route_ok[o] && iv_q[src_q[o]];
      done_cell[o*CELL_W +: CELL_W] = done_vld[o] ?
        {xslice[o], acc_q[o][CELL_W-1:SLICE_W]} : '0;
    end
  end

  always_comb begin
    src_d = src_q;
    cv_d  = cv_q;
    iv_d  = iv_q;
    for (int i = 0; i < N_PORTS; i++) begin
      sh_d[i]  = sh_q[i] >> SLICE_W;
      acc_d[i] = {xslice[i], acc_q[i][CELL_W-1:SLICE_W]};
    end
    if (load) begin
      cv_d = cfg_vld;
      iv_d = in_vld;
      for (int i = 0; i < N_PORTS; i++) begin
        src_d[i] = cfg_src[i*SRC_W +: SRC_W];
        sh_d[i]  = in_cell[i*CELL_W +: CELL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      cv_q  <= '0;
      iv_q  <= '0;
      sh_q  <= '0;
      acc_q <= '0;
    end else begin
      src_q <= src_d;
      cv_q  <= cv_d;
      iv_q  <= iv_d;
      sh_q  <= sh_d;
      acc_q <= acc_d;
    end
  end

  // R4: setting stays frozen between this plane's turns
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(src_q) && $stable(cv_q) && $stable(iv_q)));
endmodule

// File: rtl/tsx_fabric.sv
module tsx_fabric
  import tsx_pkg::*;
#(
  parameter int N_PORTS  = 4,
  parameter int N_PLANES = 4,
  parameter int CELL_W   = 32,
  localparam int SRC_W   = idx_w(N_PORTS),
  localparam int SLOT_W  = idx_w(N_PLANES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS*CELL_W-1:0] in_cell,
  input  logic [N_PORTS-1:0]        in_vld,
  input  logic [N_PORTS*SRC_W-1:0]  perm_src,
  input  logic [N_PORTS-1:0]        perm_vld,
  output logic [N_PORTS*CELL_W-1:0] out_cell,
  output logic [N_PORTS-1:0]        out_vld,
  output logic                      perm_err
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [SLOT_W-1:0] slot;
  logic              dup;
  logic [N_PORTS-1:0] cfg_vld;
  logic [N_PLANES-1:0] load_vec;
  logic [N_PLANES-1:0][N_PORTS*CELL_W-1:0] pl_cell;
  logic [N_PLANES-1:0][N_PORTS-1:0]        pl_vld;

  tsx_slot_ctr #(.N_PLANES(N_PLANES)) u_slot (
    .clk(clk), .rst_n(rst_i), .slot(slot));

  tsx_dup_check #(.N_PORTS(N_PORTS), .SRC_W(SRC_W)) u_dup (
    .perm_src(perm_src), .perm_vld(perm_vld), .dup(dup));

  // a refused matching is delivered as an all-idle setting
  assign cfg_vld = dup ? '0 : perm_vld;

  for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
    assign load_vec[p] = (slot == SLOT_W'(p));
    tsx_plane #(.N_PORTS(N_PORTS), .N_PLANES(N_PLANES), .CELL_W(CELL_W)) u_plane (
      .clk(clk), .rst_n(rst_i), .load(load_vec[p]),
      .in_cell(in_cell), .in_vld(in_vld),
      .cfg_src(perm_src), .cfg_vld(cfg_vld),
      .done_cell(pl_cell[p]), .done_vld(pl_vld[p]));
  end

  // output stage: the plane whose turn it is has just completed its cells
  logic [N_PORTS*CELL_W-1:0] oc_q, oc_d;
  logic [N_PORTS-1:0]        ov_q, ov_d;
  logic                      err_q, err_d;

  always_comb begin
    oc_d  = pl_cell[slot];
    ov_d  = pl_vld[slot];
    err_d = dup;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      oc_q  <= '0;
      ov_q  <= '0;
      err_q <= 1'b0;
    end else begin
      oc_q  <= oc_d;
      ov_q  <= ov_d;
      err_q <= err_d;
    end
  end

  assign out_cell = oc_q;
  assign out_vld  = ov_q;
  assign perm_err = err_q;

  // R3: exactly one plane takes the decision of each cycle
  p_one_load_r3: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot(load_vec));

  for (genvar o = 0; o < N_PORTS; o++) begin : g_chk
    // R5: an idle output carries no stale data
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_i)
      !ov_q[o] |-> (oc_q[o*CELL_W +: CELL_W] == '0));
  end
endmodule

// File: tb/tb_tsx_fabric.sv
module tb_tsx_fabric;
  localparam int N   = 4;
  localparam int K   = 4;
  localparam int CW  = 32;
  localparam int SW  = 2;
  localparam int LAT = K + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*CW-1:0] in_cell = '0;
  logic [N-1:0]    in_vld = '0;
  logic [N*SW-1:0] perm_src = '0;
  logic [N-1:0]    perm_vld = '0;
  logic [N*CW-1:0] out_cell;
  logic [N-1:0]    out_vld;
  logic            perm_err;

  always #10 clk = ~clk;

  tsx_fabric #(.N_PORTS(N), .N_PLANES(K), .CELL_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .in_cell(in_cell), .in_vld(in_vld),
    .perm_src(perm_src), .perm_vld(perm_vld),
    .out_cell(out_cell), .out_vld(out_vld), .perm_err(perm_err));

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // expected-result ring, one entry per cycle in flight
  logic [N*CW-1:0] exp_cell [LAT];
  logic [N-1:0]    exp_vld  [LAT];
  bit              exp_live [LAT];
  string           exp_tag  [LAT];
  bit              prev_dup = 0;
  string           prev_tag = "R1";
  int              cyc = 0;

  task automatic check(input string tag, input logic [N*CW-1:0] ac,
                       input logic [N*CW-1:0] ec, input logic [N-1:0] av,
                       input logic [N-1:0] ev);
    checks++;
    if (ac !== ec || av !== ev) begin
      fails++;
      $display("FAIL %s: out_vld=%h out_cell=%h expected out_vld=%h out_cell=%h",
               tag, av, ac, ev, ec);
    end
  endtask

  task automatic check_err(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: perm_err=%b expected %b", tag, act, expv);
    end
  endtask

  function automatic logic [CW-1:0] mk(input int c, input int i);
    return {8'(c), 8'hC0 | 8'(i), 8'(c * 7 + i), 8'(8'h5A ^ 8'(c))};
  endfunction

  // one cell time: check the slot LAT cycles old, then drive this one
  task automatic step(input string tag, input logic [N*CW-1:0] c,
                      input logic [N-1:0] iv, input logic [N*SW-1:0] ps,
                      input logic [N-1:0] pv);
    int idx;
    bit d;
    logic [N*CW-1:0] ec;
    logic [N-1:0] ev;
    @(negedge clk);
    idx = cyc % LAT;
    if (exp_live[idx])
      check(exp_tag[idx], out_cell, exp_cell[idx], out_vld, exp_vld[idx]);
    check_err(prev_tag, perm_err, prev_dup);
    d = 0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (pv[a] && pv[b] && ps[a*SW +: SW] == ps[b*SW +: SW]) d = 1;
    ec = '0;
    ev = '0;
    for (int o = 0; o < N; o++) begin
      int s;
      s = int'(ps[o*SW +: SW]);
      if (!d && pv[o] && iv[s]) begin
        ev[o] = 1'b1;
        ec[o*CW +: CW] = c[s*CW +: CW];
      end
    end
    exp_cell[idx] = ec;
    exp_vld[idx]  = ev;
    exp_live[idx] = 1;
    exp_tag[idx]  = tag;
    prev_dup = d;
    prev_tag = tag;
    in_cell = c;
    in_vld = iv;
    perm_src = ps;
    perm_vld = pv;
    cyc++;
  endtask

  function automatic logic [N*CW-1:0] cells(input int c);
    logic [N*CW-1:0] r;
    for (int i = 0; i < N; i++) r[i*CW +: CW] = mk(c, i);
    return r;
  endfunction

  function automatic logic [N*SW-1:0] rot(input int sh);
    logic [N*SW-1:0] r;
    for (int o = 0; o < N; o++) r[o*SW +: SW] = SW'((o + sh) % N);
    return r;
  endfunction

  task automatic flush(input string tag);
    for (int n = 0; n < LAT; n++) step(tag, '0, '0, '0, '0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 in reset", out_cell, '0, out_vld, '0);
    check_err("R1 in reset", perm_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", out_cell, '0, out_vld, '0);
    check_err("R1 after release", perm_err, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 settled", out_cell, '0, out_vld, '0);
  endtask

  task automatic t_single();
    step("R2 identity", cells(1), '1, rot(0), '1);
    flush("R2 drain");
    step("R2 shifted", cells(2), '1, rot(3), '1);
    flush("R2 drain");
  endtask

  task automatic t_rotate();
    for (int c = 0; c < 12; c++)
      step("R3 per-cycle matching", cells(10 + c), '1, rot(c), '1);
    flush("R3 drain");
  endtask

  task automatic t_order();
    logic [N*SW-1:0] ps;
    ps = '0;
    ps[3*SW +: SW] = SW'(1);
    for (int c = 0; c < 9; c++)
      step("R4 in-order stream", cells(40 + c), 4'b0010, ps, 4'b1000);
    flush("R4 drain");
  endtask

  task automatic t_partial();
    step("R5 masked entries", cells(60), '1, rot(1), 4'b0101);
    step("R5 none valid", cells(61), '1, rot(2), 4'b0000);
    step("R6 missing source", cells(62), 4'b1010, rot(0), '1);
    step("R6 no inputs", cells(63), 4'b0000, rot(1), '1);
    flush("R5 R6 drain");
  endtask

  task automatic t_dup();
    logic [N*SW-1:0] ps;
    ps = rot(0);
    ps[2*SW +: SW] = SW'(0);
    step("R9 before refused", cells(70), '1, rot(1), '1);
    step("R7 duplicate dropped", cells(71), '1, ps, '1);
    step("R9 after refused", cells(72), '1, rot(2), '1);
    step("R9 next", cells(73), '1, rot(3), '1);
    flush("R7 drain");
    step("R8 masked duplicate", cells(74), '1, ps, 4'b1011);
    step("R8 masked duplicate b", cells(75), '1, ps, 4'b1110);
    flush("R8 drain");
  endtask

  initial begin
    for (int n = 0; n < LAT; n++) exp_live[n] = 0;
    t_reset();
    t_single();
    t_rotate();
    t_order();
    t_partial();
    t_dup();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule